// File: doc/BRIEF.md
# I2C Bus Slave Controller with Status Flags

This block is a synchronous I2C slave that runs on the system clock. The SCL and SDA inputs first pass through a two-flop synchronizer and then a stability filter. Software picks the filter length: none, 2 clocks or 4 clocks. After filtering, the block finds START and STOP conditions and the rising and falling edges of SCL.

On the first byte after a START, the block compares the upper seven bits with a programmed 7-bit address. On a match it acknowledges and records the direction bit. It then either receives bytes from the master or sends bytes to it. The transmit/receive select input decides which.

Software controls the block through plain inputs:
- an enable
- a filter select
- the transmit/receive select
- the acknowledge value to return for received bytes

The block reports five flags: byte complete, address match, bus busy, read/write direction and the acknowledge that the master returned. A one-cycle interrupt pulse marks each completed byte. SDA is open-drain and is modelled as an output enable that pulls the line low.

Top module: `i2c_flag_slave`

## Requirements
- R1: A level change on SCL or SDA takes effect only after the synchronized level has held for N consecutive clocks. N is 1 for filter select 00, 2 for 01, and 4 for 10 or 11. Shorter pulses are discarded.
- R2: The bus-busy flag goes to 1 on a START (SDA falls while SCL is high) and back to 0 on a STOP (SDA rises while SCL is high).
- R3: The first byte after START carries the address, MSB first, in bits 7..1. If those bits equal `cfg_addr`, the match flag becomes 1 and the slave pulls SDA low during the ninth clock. Otherwise the match flag becomes 0, SDA stays released, and the slave ignores every following byte until the next START.
- R4: When the address matches, the read/write flag takes bit 0 of the address byte. A 1 means the master reads.
- R5: START clears the byte-complete flag. The flag becomes 1 at the eighth SCL rising edge of each byte the slave takes part in, together with a one-cycle `irq` pulse. It returns to 0 when the next byte begins, at the falling edge that ends the ninth clock.
- R6: When `cfg_tx` is 0, data bytes are shifted in MSB first and presented on `rx_byte`. During the ninth clock the slave drives `cfg_ackval`: 0 pulls SDA low (ACK) and 1 releases it (NACK).
- R7: When `cfg_tx` is 1, the slave sends `tx_byte` MSB first. The value is taken at the start of each byte. The received-acknowledge flag captures SDA at the ninth rising edge. A 0 there starts another byte. A 1 releases SDA until the next START or STOP.
- R8: After reset, byte-complete and received-acknowledge read 1. Match, busy and read/write read 0, and `sda_oe` and `irq` are 0.
- R9: On a 0-to-1 change of `cfg_en`, all five flags return to their reset values in the next cycle. The control inputs keep their effect on the transfers that follow.
- R10: While `cfg_en` is 0, `sda_oe` is 0 and bus activity changes no flag and raises no interrupt.
- R11: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_en | input | 1 | Block enable |
| cfg_dbsel | input | 2 | Input filter length select |
| cfg_tx | input | 1 | 1: slave transmits data, 0: slave receives |
| cfg_ackval | input | 1 | Acknowledge value returned for received bytes |
| cfg_addr | input | ADDR_W | Programmed slave address |
| tx_byte | input | ADDR_W+1 | Byte to send in transmit mode |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| rx_byte | output | ADDR_W+1 | Last received data byte |
| st_done | output | 1 | Byte-complete flag |
| st_match | output | 1 | Address-match flag |
| st_busy | output | 1 | Bus-busy flag |
| st_rw | output | 1 | Direction bit of the matched address byte |
| st_rxack | output | 1 | Acknowledge received from the master |
| irq | output | 1 | One-cycle byte-complete pulse |

## Verification
The hardest case to reach from the ports is a pulse whose width sits exactly on the filter threshold. A pulse that lasts one clock fewer than required must vanish, while one of exactly the required length must register as a START and a STOP.

The bench sweeps low pulses of 1 to 5 clocks on an idle SDA line across every filter select. It detects whether the pulse was seen by watching whether the busy flag rose at any point. Transmit-side termination after a NACK is reached by a third read after the NACK, which must return all ones.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK,
    ST_WAIT
  } slv_state_t;

  typedef struct packed {
    logic done;
    logic match;
    logic busy;
    logic rw;
    logic rxack;
  } slv_flags_t;

  localparam slv_flags_t FLAGS_RST = '{done: 1'b1, match: 1'b0, busy: 1'b0,
                                       rw: 1'b0, rxack: 1'b1};

endpackage

// File: rtl/i2cs_glitch_filt.sv
module i2cs_glitch_filt #(
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_LEN   = 2,
  parameter int LONG_LEN    = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pin,
  input  logic [1:0] dbsel,
  output logic       level
);
  localparam int CNT_W = $clog2(LONG_LEN + 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   raw;
  logic [CNT_W-1:0]       cnt;
  logic [CNT_W-1:0]       cnt_nxt;
  logic [CNT_W-1:0]       need_len;

  always_ff @(posedge clk) begin
    if (rst) sync_q <= '1;
    else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
  end

  assign raw     = sync_q[SYNC_STAGES-1];
  assign cnt_nxt = cnt + CNT_W'(1);

  always_comb begin
    case (dbsel)
      2'b00:   need_len = CNT_W'(1);
      2'b01:   need_len = CNT_W'(SHORT_LEN);
      default: need_len = CNT_W'(LONG_LEN);
    endcase
  end

  // level follows raw only after raw has differed for need_len clocks
  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b1;
      cnt   <= '0;
    end else if (raw == level) begin
      cnt <= '0;
    end else if (cnt_nxt == need_len) begin
      level <= raw;
      cnt   <= '0;
    end else begin
      cnt <= cnt_nxt;
    end
  end

endmodule

// File: rtl/i2cs_bus_cond.sv
module i2cs_bus_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise  =  scl & ~scl_q;
  assign scl_fall  = ~scl &  scl_q;
  assign start_det =  scl &  scl_q &  sda_q & ~sda;
  assign stop_det  =  scl &  scl_q & ~sda_q &  sda;

endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
  import i2cs_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                tx_sel,
  input  logic                ack_val,
  input  logic [ADDR_W-1:0]   own_addr,
  input  logic [ADDR_W:0]     tx_data,
  input  logic                sda,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                start_det,
  input  logic                stop_det,
  output slv_flags_t          flags,
  output logic                irq,
  output logic                oe,
  output logic [ADDR_W:0]     rx_data
);
  localparam int DATA_W = ADDR_W + 1;
  localparam int CW     = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(DATA_W - 1);
  localparam logic [CW-1:0] ACK_SLOT = CW'(DATA_W);

  slv_state_t        state;
  logic [CW-1:0]     bit_cnt;
  logic [DATA_W-1:0] shreg;
  logic              en_q;
  logic [DATA_W-1:0] byte_in;

  assign byte_in = {shreg[DATA_W-2:0], sda};

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      bit_cnt <= '0;
      shreg   <= '0;
      rx_data <= '0;
      flags   <= FLAGS_RST;
      irq     <= 1'b0;
      oe      <= 1'b0;
      en_q    <= 1'b0;
    end else begin
      en_q <= en;
      irq  <= 1'b0;
      if (!en) begin
        state <= ST_IDLE;
        oe    <= 1'b0;
      end else if (!en_q) begin
        flags   <= FLAGS_RST;
        state   <= ST_IDLE;
        bit_cnt <= '0;
        oe      <= 1'b0;
      end else if (start_det) begin
        flags.busy  <= 1'b1;
        flags.done  <= 1'b0;
        flags.match <= 1'b0;
        state       <= ST_ADDR;
        bit_cnt     <= '0;
        oe          <= 1'b0;
      end else if (stop_det) begin
        flags.busy <= 1'b0;
        state      <= ST_IDLE;
        oe         <= 1'b0;
      end else begin
        case (state)
          ST_ADDR: begin
            if (scl_rise && bit_cnt != ACK_SLOT) begin
              shreg   <= byte_in;
              bit_cnt <= bit_cnt + CW'(1);
              if (bit_cnt == LAST_BIT) begin
                if (shreg[ADDR_W-1:0] == own_addr) begin
                  flags.match <= 1'b1;
                  flags.rw    <= sda;
                  flags.done  <= 1'b1;
                  irq         <= 1'b1;
                end else begin
                  flags.match <= 1'b0;
                  state       <= ST_WAIT;
                end
              end
            end else if (scl_fall && bit_cnt == ACK_SLOT) begin
              oe    <= 1'b1;
              state <= ST_ADDR_ACK;
            end
          end
          ST_ADDR_ACK: begin
            if (scl_fall) begin
              bit_cnt    <= '0;
              flags.done <= 1'b0;
              if (tx_sel) begin
                shreg <= tx_data;
                oe    <= ~tx_data[DATA_W-1];
                state <= ST_TX;
              end else begin
                oe    <= 1'b0;
                state <= ST_RX;
              end
            end
          end
          ST_RX: begin
            if (scl_rise && bit_cnt != ACK_SLOT) begin
              shreg   <= byte_in;
              bit_cnt <= bit_cnt + CW'(1);
              if (bit_cnt == LAST_BIT) begin
                rx_data    <= byte_in;
                flags.done <= 1'b1;
                irq        <= 1'b1;
              end
            end else if (scl_fall && bit_cnt == ACK_SLOT) begin
              oe    <= ~ack_val;
              state <= ST_RX_ACK;
            end
          end
          ST_RX_ACK: begin
            if (scl_fall) begin
              oe         <= 1'b0;
              bit_cnt    <= '0;
              flags.done <= 1'b0;
              state      <= ST_RX;
            end
          end
          ST_TX: begin
            if (scl_rise && bit_cnt != ACK_SLOT) begin
              shreg   <= {shreg[DATA_W-2:0], 1'b0};
              bit_cnt <= bit_cnt + CW'(1);
              if (bit_cnt == LAST_BIT) begin
                flags.done <= 1'b1;
                irq        <= 1'b1;
              end
            end else if (scl_fall) begin
              if (bit_cnt == ACK_SLOT) begin
                oe    <= 1'b0;
                state <= ST_TX_ACK;
              end else begin
                oe <= ~shreg[DATA_W-1];
              end
            end
          end
          ST_TX_ACK: begin
            if (scl_rise) begin
              flags.rxack <= sda;
            end else if (scl_fall) begin
              if (!flags.rxack) begin
                shreg      <= tx_data;
                oe         <= ~tx_data[DATA_W-1];
                bit_cnt    <= '0;
                flags.done <= 1'b0;
                state      <= ST_TX;
              end else begin
                state <= ST_WAIT;
              end
            end
          end
          default: begin
            oe <= 1'b0;
          end
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_flag_slave.sv
module i2c_flag_slave
  import i2cs_pkg::*;
#(
  parameter int ADDR_W      = 7,
  parameter int SYNC_STAGES = 2,
  parameter int SHORT_LEN   = 2,
  parameter int LONG_LEN    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_en,
  input  logic [1:0]        cfg_dbsel,
  input  logic              cfg_tx,
  input  logic              cfg_ackval,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [ADDR_W:0]   tx_byte,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [ADDR_W:0]   rx_byte,
  output logic              st_done,
  output logic              st_match,
  output logic              st_busy,
  output logic              st_rw,
  output logic              st_rxack,
  output logic              irq
);
  localparam int NUM_LINES = 2;  // index 0: SCL, 1: SDA

  logic [NUM_LINES-1:0] line_raw;
  logic [NUM_LINES-1:0] line_flt;
  logic scl_rise, scl_fall, start_det, stop_det;
  slv_flags_t flags;

  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    i2cs_glitch_filt #(
      .SYNC_STAGES(SYNC_STAGES),
      .SHORT_LEN  (SHORT_LEN),
      .LONG_LEN   (LONG_LEN)
    ) u_filt (
      .clk  (clk),
      .rst  (rst),
      .pin  (line_raw[g]),
      .dbsel(cfg_dbsel),
      .level(line_flt[g])
    );
  end

  i2cs_bus_cond u_cond (
    .clk      (clk),
    .rst      (rst),
    .scl      (line_flt[0]),
    .sda      (line_flt[1]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2cs_engine #(.ADDR_W(ADDR_W)) u_eng (
    .clk      (clk),
    .rst      (rst),
    .en       (cfg_en),
    .tx_sel   (cfg_tx),
    .ack_val  (cfg_ackval),
    .own_addr (cfg_addr),
    .tx_data  (tx_byte),
    .sda      (line_flt[1]),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .flags    (flags),
    .irq      (irq),
    .oe       (sda_oe),
    .rx_data  (rx_byte)
  );

  assign st_done  = flags.done;
  assign st_match = flags.match;
  assign st_busy  = flags.busy;
  assign st_rw    = flags.rw;
  assign st_rxack = flags.rxack;

endmodule

// File: rtl/i2c_flag_slave_chk.sv
module i2c_flag_slave_chk (
  input logic clk,
  input logic rst,
  input logic cfg_en,
  input logic scl_i,
  input logic sda_oe,
  input logic irq,
  input logic st_done,
  input logic st_match,
  input logic st_busy,
  input logic st_rw,
  input logic st_rxack
);

  // R10
  disabled_release_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_en |=> !sda_oe);

  // R10
  disabled_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg_en) |-> $stable({st_done, st_match, st_busy, st_rw, st_rxack}));

  // R5
  irq_single_chk: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  // R5
  irq_done_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> st_done);

  // R9
  enable_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (cfg_en && !$past(cfg_en)) |=>
      (st_done && st_rxack && !st_busy && !st_match && !st_rw));

  // R11
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (rst || !cfg_en)
    !$stable(sda_oe) |-> !scl_i);

endmodule

bind i2c_flag_slave i2c_flag_slave_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .cfg_en  (cfg_en),
  .scl_i   (scl_i),
  .sda_oe  (sda_oe),
  .irq     (irq),
  .st_done (st_done),
  .st_match(st_match),
  .st_busy (st_busy),
  .st_rw   (st_rw),
  .st_rxack(st_rxack)
);

// File: tb/i2c_flag_slave_bench.sv
`timescale 1ns/1ps
module i2c_flag_slave_bench;
  localparam int Q = 20;
  localparam logic [6:0] OWN = 7'h5A;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst, cfg_en, cfg_tx, cfg_ackval;
  logic [1:0] cfg_dbsel;
  logic [6:0] cfg_addr;
  logic [7:0] tx_byte, rx_byte;
  logic       m_scl, m_sda;
  logic       sda_oe, st_done, st_match, st_busy, st_rw, st_rxack, irq;
  logic       sda_bus;

  assign sda_bus = m_sda & ~sda_oe;

  i2c_flag_slave u_i2c_flag_slave (
    .clk(clk), .rst(rst), .cfg_en(cfg_en), .cfg_dbsel(cfg_dbsel),
    .cfg_tx(cfg_tx), .cfg_ackval(cfg_ackval), .cfg_addr(cfg_addr),
    .tx_byte(tx_byte), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .rx_byte(rx_byte), .st_done(st_done), .st_match(st_match),
    .st_busy(st_busy), .st_rw(st_rw), .st_rxack(st_rxack), .irq(irq)
  );

  int errors = 0;
  int checks = 0;
  int irq_cnt = 0;
  int busy_cyc = 0;
  int r11_viol = 0;
  logic prev_oe = 1'b0;
  logic prev_scl = 1'b1;
  logic last_done;

  always @(negedge clk) begin
    if (irq) irq_cnt++;
    if (st_busy) busy_cyc++;
    if (cfg_en && (sda_oe != prev_oe) && m_scl && prev_scl) r11_viol++;
    prev_oe  = sda_oe;
    prev_scl = m_scl;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(Q);
    m_scl = 1'b1; tick(Q);
    m_sda = 1'b1; tick(2 * Q);
  endtask

  task automatic write_bit(input logic b);
    m_sda = b;    tick(Q);
    m_scl = 1'b1; tick(2 * Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic read_bit(output logic b);
    m_sda = 1'b1; tick(Q);
    m_scl = 1'b1; tick(Q);
    b = sda_bus;
    last_done = st_done;
    tick(Q);
    m_scl = 1'b0; tick(Q);
  endtask

  task automatic write_byte(input logic [7:0] v, output logic ack);
    for (int k = 7; k >= 0; k--) write_bit(v[k]);
    read_bit(ack);
  endtask

  task automatic read_byte(input logic [7:0] nxt, input logic mack, output logic [7:0] v);
    logic b;
    v = '0;
    for (int k = 0; k < 8; k++) begin
      read_bit(b);
      v = {v[6:0], b};
    end
    tx_byte = nxt;
    write_bit(mack);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic ack;
    logic [7:0] v;
    int i0, b0;
    rst = 1'b1; cfg_en = 1'b0; cfg_dbsel = 2'b00; cfg_tx = 1'b0;
    cfg_ackval = 1'b0; cfg_addr = OWN; tx_byte = 8'h00;
    m_scl = 1'b1; m_sda = 1'b1;
    tick(6);
    // R8 reset values
    chk("R8 done", st_done, 1); chk("R8 rxack", st_rxack, 1);
    chk("R8 match", st_match, 0); chk("R8 busy", st_busy, 0);
    chk("R8 rw", st_rw, 0); chk("R8 oe", sda_oe, 0); chk("R8 irq", irq, 0);
    rst = 1'b0;
    tick(2);
    cfg_en = 1'b1;
    tick(10);

    // R1 filter threshold sweep with SDA pulses on an idle bus
    for (int d = 0; d < 4; d++) begin
      cfg_dbsel = d[1:0];
      tick(20);
      for (int w = 1; w <= 5; w++) begin
        int need;
        need = (d == 0) ? 1 : (d == 1) ? 2 : 4;
        b0 = busy_cyc;
        m_sda = 1'b0; tick(w);
        m_sda = 1'b1; tick(30);
        chk($sformatf("R1 dbsel=%0d width=%0d seen", d, w), (busy_cyc != b0), (w >= need));
      end
      chk("R1 bus idle after sweep", st_busy, 0);
    end

    // R2 busy flag
    cfg_dbsel = 2'b01;
    bus_start();
    chk("R2 busy after start", st_busy, 1);
    bus_stop();
    chk("R2 busy after stop", st_busy, 0);

    // R3 / R4 address sweep, one flipped bit per pass plus two matches
    cfg_dbsel = 2'b10;
    for (int i = 0; i < 9; i++) begin
      logic [6:0] a;
      logic rw, hit;
      a   = (i >= 7) ? OWN : (OWN ^ (7'd1 << i));
      rw  = (i == 7) ? 1'b1 : (i == 8) ? 1'b0 : i[0];
      hit = (a == OWN);
      i0  = irq_cnt;
      bus_start();
      write_byte({a, rw}, ack);
      chk($sformatf("R3 ack addr=%0h", a), ack, !hit);
      chk($sformatf("R3 match addr=%0h", a), st_match, hit);
      chk($sformatf("R5 done at ack addr=%0h", a), last_done, hit);
      chk($sformatf("R5 irq addr=%0h", a), irq_cnt - i0, hit);
      if (hit) chk($sformatf("R4 rw addr=%0h", a), st_rw, rw);
      if (i == 0) begin
        write_byte(8'hB4, ack);
        chk("R3 ignored byte ack", ack, 1);
        chk("R3 ignored byte irq", irq_cnt - i0, 0);
      end
      bus_stop();
    end

    // R6 receive with varying acknowledge value
    cfg_dbsel = 2'b01; cfg_tx = 1'b0;
    bus_start();
    write_byte({OWN, 1'b0}, ack);
    chk("R6 addr ack", ack, 0);
    for (int j = 0; j < 5; j++) begin
      logic [7:0] val;
      val = (j == 0) ? 8'h00 : (j == 1) ? 8'hFF : (j == 2) ? 8'hA5 : (j == 3) ? 8'h3C : 8'h81;
      cfg_ackval = (j == 3);
      i0 = irq_cnt;
      write_byte(val, ack);
      chk($sformatf("R6 ack byte%0d", j), ack, (j == 3));
      chk($sformatf("R6 data byte%0d", j), rx_byte, val);
      chk($sformatf("R5 done in ack slot byte%0d", j), last_done, 1);
      chk($sformatf("R5 irq byte%0d", j), irq_cnt - i0, 1);
      chk($sformatf("R5 done cleared byte%0d", j), st_done, 0);
    end
    cfg_ackval = 1'b0;
    bus_stop();
    chk("R2 busy after rx stop", st_busy, 0);

    // R7 transmit
    cfg_dbsel = 2'b00; cfg_tx = 1'b1; tx_byte = 8'hC3;
    i0 = irq_cnt;
    bus_start();
    write_byte({OWN, 1'b1}, ack);
    chk("R7 addr ack", ack, 0);
    chk("R4 rw read", st_rw, 1);
    read_byte(8'h5E, 1'b0, v);
    chk("R7 first byte", v, 8'hC3);
    chk("R7 rxack after ACK", st_rxack, 0);
    read_byte(8'h00, 1'b1, v);
    chk("R7 second byte", v, 8'h5E);
    chk("R7 rxack after NACK", st_rxack, 1);
    chk("R7 released after NACK", sda_oe, 0);
    read_byte(8'h00, 1'b1, v);
    chk("R7 no drive after NACK", v, 8'hFF);
    chk("R5 irq count tx", irq_cnt - i0, 3);
    bus_stop();

    // R9 re-enable clears flags, controls keep effect
    bus_start();
    chk("R9 busy before toggle", st_busy, 1);
    chk("R9 rw before toggle", st_rw, 1);
    cfg_en = 1'b0; tick(5);
    cfg_en = 1'b1; tick(3);
    chk("R9 done", st_done, 1); chk("R9 rxack", st_rxack, 1);
    chk("R9 busy", st_busy, 0); chk("R9 match", st_match, 0);
    chk("R9 rw", st_rw, 0);
    bus_stop();
    tx_byte = 8'h96;
    bus_start();
    write_byte({OWN, 1'b1}, ack);
    read_byte(8'h00, 1'b1, v);
    chk("R9 transmit select kept", v, 8'h96);
    bus_stop();

    // R10 disabled block ignores the bus
    cfg_en = 1'b0; tick(5);
    i0 = irq_cnt; b0 = busy_cyc;
    bus_start();
    write_byte({OWN, 1'b0}, ack);
    chk("R10 no ack", ack, 1);
    chk("R10 busy untouched", busy_cyc - b0, 0);
    chk("R10 irq untouched", irq_cnt - i0, 0);
    chk("R10 oe released", sda_oe, 0);
    bus_stop();
    cfg_en = 1'b1; tick(5);

    chk("R11 oe changes only with SCL low", r11_viol, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule